// File: doc/BRIEF.md
# Toggle-Handshake Single-Port RAM

This block is a single-port synchronous word memory for a datapath that is built as a state machine. The client does not raise a strobe to ask for an access. It inverts its one-bit request flag `usr_en` so that the flag no longer matches the memory's one-bit acknowledge register `ack_en`. While the two differ, the memory decodes one access from `wr_en`. A nonzero `wr_en` selects a write, which stores `wdata` at `addr`. A zero `wr_en` selects a read, which loads the word at `addr` into `rdata`.

On the clock edge that services the access, the memory copies `usr_en` into `ack_en`. The two flags are then equal again, and that equality is the acknowledge. The client sees the acknowledge, and any read result, one edge after it presented the request. It makes its next request by inverting `usr_en` again.

The controller's state is the acknowledge bit. Each cycle it is decoded against the request flag and `wr_en` into one of three access kinds. IDLE means the flags are equal. WRITE means the flags differ and `wr_en` is 1. READ means the flags differ and `wr_en` is 0. The transitions are as follows:
- IDLE stays IDLE while `usr_en` is unchanged.
- IDLE becomes WRITE or READ when `usr_en` is inverted.
- WRITE and READ always return to IDLE at the next edge, because `ack_en` takes the value of `usr_en` there.

Top module: `toggle_ram`

## Requirements
- R1: When `ack_en` equals `usr_en` (IDLE), no edge changes `ack_en`, `rdata` or any stored word, whatever `wr_en`, `addr` and `wdata` are.
- R2: When `ack_en` differs from `usr_en` and `wr_en` is 1 with `addr` below DEPTH, `wdata` is stored in word `addr`. A later read of that address returns it.
- R3: When `ack_en` differs from `usr_en` and `wr_en` is 0 with `addr` below DEPTH, the word at `addr` appears on `rdata` right after the next rising edge, not before it. This includes the last word, DEPTH-1.
- R4: Every serviced access, read or write, loads `usr_en` into `ack_en` on the same edge, so the two flags compare equal after that edge.
- R5: A write leaves `rdata` unchanged, and a read leaves every stored word unchanged.
- R6: An access with `addr` at or above DEPTH still acknowledges as in R4. As a write it changes no stored word, including the word whose index equals the low address bits. As a read it puts 0 on `rdata`.
- R7: Reset (`rst` high, synchronous) clears `ack_en` and `rdata` to 0. Stored words are not initialised.
- R8: `rdata` holds the result of the most recent completed read until the next read completes. Idle cycles and writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every update happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| usr_en | input | 1 | Client request flag; inverting it requests one access |
| wr_en | input | 1 | 1 selects a write, 0 selects a read |
| addr | input | ADDR_W | Word index of the access |
| wdata | input | DATA_W | Data stored by a write |
| rdata | output | DATA_W | Registered read result |
| ack_en | output | 1 | Acknowledge register; equals `usr_en` when no access is pending |

## Verification
The bench holds `wr_en` high with a live address and data while the flags are equal. A design that wrote whenever `wr_en` was high would corrupt that word, and the corruption shows up on the following read. An out-of-range write goes to an address whose low bits alias a filled word. A design that truncated the address would overwrite that word, and a design that skipped the acknowledge would leave `ack_en` stuck different from `usr_en`. Reads are scored one edge after the request, covering both the last valid word and an out-of-range read that must return zero. This catches designs that leave the previous value on `rdata`, answer combinationally, or disturb `rdata` during writes and idle cycles.

// File: rtl/toggle_ram_pkg.sv
package toggle_ram_pkg;

    // Access kind decoded each cycle from the acknowledge/request pair.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_kind_t;

endpackage

// File: rtl/tr_req_decode.sv
module tr_req_decode
    import toggle_ram_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              ack_q,
    input  logic              usr_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind,
    output logic              in_range
);
    localparam logic [ADDR_W:0] DEPTH_EXT = DEPTH[ADDR_W:0];

    always_comb begin
        in_range = ({1'b0, addr} < DEPTH_EXT);
        if (ack_q == usr_en)
            kind = ACC_IDLE;
        else if (wr_en)
            kind = ACC_WRITE;
        else
            kind = ACC_READ;
    end
endmodule

// File: rtl/tr_mem_array.sv
module tr_mem_array #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[idx] <= wdata;
    end

    assign rword = store[idx];
endmodule

// File: rtl/toggle_ram.sv
module toggle_ram
    import toggle_ram_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack_en
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    acc_kind_t         kind;
    logic              in_range;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] mem_word;

    tr_req_decode #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .ack_q    (ack_en),
        .usr_en   (usr_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .kind     (kind),
        .in_range (in_range)
    );

    generate
        if (ADDR_W >= IDX_W) begin : g_idx_trunc
            assign mem_idx = addr[IDX_W-1:0];
        end else begin : g_idx_pad
            assign mem_idx = {{(IDX_W-ADDR_W){1'b0}}, addr};
        end
    endgenerate

    assign mem_we = (kind == ACC_WRITE) && in_range;

    tr_mem_array #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .idx   (mem_idx),
        .wdata (wdata),
        .rword (mem_word)
    );

    // State register: the acknowledge bit follows the request on service.
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_en <= 1'b0;
        end else begin
            unique case (kind)
                ACC_IDLE:  ack_en <= ack_en;
                ACC_WRITE: ack_en <= usr_en;
                ACC_READ:  ack_en <= usr_en;
                default:   ack_en <= ack_en;
            endcase
        end
    end

    // Output register: only a serviced read updates the read result.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            unique case (kind)
                ACC_READ:  rdata <= in_range ? mem_word : '0;
                ACC_IDLE:  rdata <= rdata;
                ACC_WRITE: rdata <= rdata;
                default:   rdata <= rdata;
            endcase
        end
    end
endmodule

// File: rtl/tr_ram_checks.sv
module tr_ram_checks #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              usr_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              ack_en
);
    localparam logic [ADDR_W:0] LIMIT = DEPTH[ADDR_W:0];

    // R1: idle leaves the acknowledge and read result untouched
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (ack_en == usr_en) |=> ($stable(ack_en) && $stable(rdata)));

    // R4: a pending request is acknowledged on the next edge
    a_r4_ack_copy: assert property (@(posedge clk) disable iff (rst)
        (ack_en != usr_en) |=> (ack_en == $past(usr_en)));

    // R5: a write does not disturb the read result
    a_r5_write_keeps_rdata: assert property (@(posedge clk) disable iff (rst)
        ((ack_en != usr_en) && wr_en) |=> $stable(rdata));

    // R6: an out-of-range read returns zero
    a_r6_oor_read_zero: assert property (@(posedge clk) disable iff (rst)
        ((ack_en != usr_en) && !wr_en && ({1'b0, addr} >= LIMIT)) |=> (rdata == '0));

    // R7: reset clears the acknowledge and read result
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> ((ack_en == 1'b0) && (rdata == '0)));

    // R8: without a serviced read the read result holds
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !((ack_en != usr_en) && !wr_en) |=> $stable(rdata));
endmodule

bind toggle_ram tr_ram_checks #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_checks (
    .clk    (clk),
    .rst    (rst),
    .usr_en (usr_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .rdata  (rdata),
    .ack_en (ack_en)
);

// File: tb/toggle_ram_bench.sv
`timescale 1ns/1ps
module toggle_ram_bench;
    localparam int DEPTH  = 16;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              usr_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              ack_en;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] model [DEPTH];
    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];
    logic [DATA_W-1:0] last_rd = '0;

    always #5 clk = ~clk;

    toggle_ram #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_toggle_ram (
        .clk    (clk),
        .rst    (rst),
        .usr_en (usr_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .ack_en (ack_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: presents one access, records the expected read result, checks the acknowledge.
    task automatic access(input bit w, input int a, input int d, input string tag);
        @(posedge clk); #2;
        wr_en = w;
        addr  = ADDR_W'(a);
        wdata = DATA_W'(d);
        if (w) begin
            if (a < DEPTH) model[a] = DATA_W'(d);
        end else begin
            last_rd = (a < DEPTH) ? model[a] : '0;
            exp_q.push_back(last_rd);
            tag_q.push_back(tag);
        end
        usr_en = ~usr_en;
        @(posedge clk); #2;
        check(ack_en == usr_en, "R4 ack after access", int'(ack_en), int'(usr_en));
        if (w) check(rdata == last_rd, "R5 write keeps rdata", int'(rdata), int'(last_rd));
    endtask

    // Monitor: a read pending before an edge is scored just after that edge.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (ack_en != usr_en) && !wr_en) begin
                @(posedge clk); #1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected read", int'(rdata), 0);
                end else begin
                    logic [DATA_W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rdata == e, t, int'(rdata), int'(e));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(ack_en == 1'b0, "R7 reset ack", int'(ack_en), 0);
        check(rdata == '0, "R7 reset rdata", int'(rdata), 0);
        rst = 1'b0;

        // R2: fill every word with a pattern, then read them all (R3 includes word DEPTH-1)
        for (int i = 0; i < DEPTH; i++) access(1'b1, i, (i * 37 + 5) & 8'hFF, "R2 write");
        for (int i = 0; i < DEPTH; i++) access(1'b0, i, 0, "R3 read back");
        access(1'b0, DEPTH - 1, 0, "R3 last word");

        // R3: result appears only after the edge, not combinationally
        @(posedge clk); #2;
        wr_en = 1'b0; addr = 5'd2; exp_q.push_back(model[2]); tag_q.push_back("R3 timed read");
        usr_en = ~usr_en;
        #1;
        check(rdata == last_rd, "R3 no early rdata", int'(rdata), int'(last_rd));
        last_rd = model[2];
        @(posedge clk); #2;
        check(ack_en == usr_en, "R4 timed ack", int'(ack_en), int'(usr_en));

        // R1: idle with write enable high and live data
        @(posedge clk); #2;
        wr_en = 1'b1; addr = 5'd3; wdata = 8'hAA;
        repeat (4) @(posedge clk);
        #2;
        check(ack_en == usr_en, "R1 idle ack stable", int'(ack_en), int'(usr_en));
        check(rdata == last_rd, "R1 idle rdata stable", int'(rdata), int'(last_rd));
        access(1'b0, 3, 0, "R1 idle no write");

        // R5: a read leaves memory unchanged (reread)
        access(1'b0, 7, 0, "R5 read once");
        access(1'b0, 7, 0, "R5 read again");

        // R6: out-of-range write aliasing word 4, out-of-range read gives zero
        access(1'b1, DEPTH + 4, 8'h5A, "R6 oor write");
        access(1'b0, 4, 0, "R6 alias word intact");
        access(1'b0, DEPTH + 9, 0, "R6 oor read zero");
        access(1'b0, 2 * DEPTH - 1, 0, "R6 top address zero");

        // R8: read result held across writes and idle
        access(1'b0, 9, 0, "R8 read");
        access(1'b1, 9, 8'h11, "R8 write after read");
        access(1'b1, 10, 8'h22, "R8 second write");
        repeat (3) @(posedge clk);
        #2;
        check(rdata == last_rd, "R8 rdata held", int'(rdata), int'(last_rd));
        access(1'b0, 9, 0, "R2 overwrite visible");

        // R7: reset mid-run clears the read result
        access(1'b0, 1, 0, "R7 pre-reset read");
        @(posedge clk); #2;
        rst = 1'b1; usr_en = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check(ack_en == 1'b0, "R7 mid reset ack", int'(ack_en), 0);
        check(rdata == '0, "R7 mid reset rdata", int'(rdata), 0);
        rst = 1'b0;
        last_rd = '0;
        access(1'b0, 1, 0, "R3 read after reset");

        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, "R3 all reads scored", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule